// File: doc/BRIEF.md
# Status Register Write-Lock Controller

This block sits on the flash side of a serial memory and decides whether a status-register write may land. The command decoder in front of it passes it single-cycle strobes: the normal write enable, the volatile-only write enable, and the status write with its 16-bit data word. The block keeps two copies of the status word. The non-volatile copy survives power cycles. The volatile copy is the one in force and the one read back.

Two protect bits in the volatile copy select one of four lock modes: free, pin-guarded, locked until power-down and locked for good. The lock-mode value is formed as {upper protect bit, lower protect bit}, so none is 0, pin is 1, reboot is 2 and permanent is 3. A parameter picks between two layouts. In the 3-bit-protect layout, mode 3 written to the non-volatile copy sets a sticky permanent lock. In the 4-bit-protect layout, either mode with the upper bit set only lasts until power-down. The power-up reset (`rst_ni`, synchronous, active low) reloads the volatile copy from the non-volatile one and drops the power-down lock.

Top module: `sreg_wlock_ctrl`

## Requirements
- R1: While `rst_ni` is low at a clock edge, `wel_o` and `busy_o` go to 0. `sr_o` is loaded from `nv_o` with bit 8 cleared, unless `perm_lock_o` is 1.
- R2: With bits 8 and 7 of the volatile copy both 0, a status write is accepted whenever the enable latch is set, whatever the pin level. A status write without a prior enable changes nothing.
- R3: With bit 8 = 0 and bit 7 = 1, a status write is accepted only when the enable latch is set and `wp_pin_i` is 1.
- R4: With bit 8 = 1 in the volatile copy, every status write is refused until the next reset, which clears that bit.
- R5: With `BP4_LAYOUT=0`, an accepted non-volatile write with bits 8 and 7 both 1 sets `perm_lock_o`. That bit survives reset and refuses all later writes. With `BP4_LAYOUT=1`, the same write locks only until reset.
- R6: A status write following the volatile enable (`vwren_i`) changes only `sr_o`. `nv_o` stays the same and `busy_o` stays 0.
- R7: A status write following the normal enable (`wren_i`) updates both copies. `busy_o` is then 1 for exactly `WR_CYC` cycles.
- R8: The enable latch clears at the edge of any status write strobe, whether the write is accepted or refused.
- R9: While `busy_o` is 1, all three strobes are ignored.
- R10: Data bits 0 and 1 are never stored. `sr_o` bit 0 reads `busy_o` and bit 1 reads `wel_o`.
- R11: `nv_o` keeps its value across reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, synchronous, active low |
| wren_i | input | 1 | Normal write-enable strobe |
| vwren_i | input | 1 | Volatile-only write-enable strobe |
| wrsr_i | input | 1 | Status write strobe |
| wr_data_i | input | 16 | Status word to write |
| wp_pin_i | input | 1 | Write-protect pin, 1 = writes allowed |
| sr_o | output | 16 | Volatile status word, with busy and enable bits merged in |
| nv_o | output | 16 | Non-volatile status copy |
| wel_o | output | 1 | Enable latch |
| busy_o | output | 1 | Non-volatile write in progress |
| perm_lock_o | output | 1 | Sticky permanent lock |

## Verification
Every strobe takes effect at the clock edge that samples it. `sr_o`, `nv_o`, `wel_o` and `perm_lock_o` are therefore due one edge later. The bench drives strobes at falling edges and samples at the next falling edge, which is the first point after that single register stage. `busy_o` rises at that same edge. The bench counts the falling-edge samples that show it high and compares the count with `WR_CYC`. Reset effects are checked at the falling edge after `rst_ni` is released, by which point two reset edges have been applied.

// File: rtl/sreg_wlock_pkg.sv
package sreg_wlock_pkg;
   // which enable armed the next status write
   typedef enum logic {
      EN_NV  = 1'b0,
      EN_VOL = 1'b1
   } en_kind_e;

   // lock mode formed as {upper protect bit, lower protect bit}
   typedef enum logic [1:0] {
      LK_NONE   = 2'd0,
      LK_PIN    = 2'd1,
      LK_REBOOT = 2'd2,
      LK_PERM   = 2'd3
   } lock_mode_e;
endpackage

// File: rtl/srl_lock_decode.sv
module srl_lock_decode
   import sreg_wlock_pkg::*;
(
   input  logic srp0_i,
   input  logic srp1_i,
   input  logic perm_i,
   input  logic wp_pin_i,
   output logic allow_o
);
   lock_mode_e mode;

   always_comb begin
      mode = lock_mode_e'({srp1_i, srp0_i});
      unique case (mode)
         LK_NONE: allow_o = 1'b1;
         LK_PIN:  allow_o = wp_pin_i;
         default: allow_o = 1'b0;
      endcase
      if (perm_i) allow_o = 1'b0;
   end
endmodule

// File: rtl/srl_enable_latch.sv
module srl_enable_latch
   import sreg_wlock_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     set_nv_i,
   input  logic     set_vol_i,
   input  logic     clr_i,
   output logic     wel_o,
   output en_kind_e kind_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wel_o  <= 1'b0;
         kind_o <= EN_NV;
      end else if (clr_i) begin
         wel_o  <= 1'b0;
      end else if (set_nv_i) begin
         wel_o  <= 1'b1;
         kind_o <= EN_NV;
      end else if (set_vol_i) begin
         wel_o  <= 1'b1;
         kind_o <= EN_VOL;
      end
   end

   AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !wel_o); // R8
endmodule

// File: rtl/srl_busy_timer.sv
module srl_busy_timer #(
   parameter int unsigned WR_CYC = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   localparam int unsigned CNT_W = $clog2(WR_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (start_i)              cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_LOAD); // R7
   AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o); // R7
endmodule

// File: rtl/sreg_wlock_ctrl.sv
module sreg_wlock_ctrl
   import sreg_wlock_pkg::*;
#(
   parameter int unsigned SR_W       = 16,
   parameter int unsigned BUSY_POS   = 0,
   parameter int unsigned WEL_POS    = 1,
   parameter int unsigned SRP0_POS   = 7,
   parameter int unsigned SRP1_POS   = 8,
   parameter bit          BP4_LAYOUT = 1'b0,
   parameter int unsigned WR_CYC     = 8,
   parameter logic [15:0] NV_INIT    = 16'h0000
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        wren_i,
   input  logic        vwren_i,
   input  logic        wrsr_i,
   input  logic [15:0] wr_data_i,
   input  logic        wp_pin_i,
   output logic [15:0] sr_o,
   output logic [15:0] nv_o,
   output logic        wel_o,
   output logic        busy_o,
   output logic        perm_lock_o
);
   localparam logic [SR_W-1:0] RO_MASK   = (SR_W'(1) << BUSY_POS) | (SR_W'(1) << WEL_POS);
   localparam logic [SR_W-1:0] SRP1_MASK = SR_W'(1) << SRP1_POS;

   // elaboration-time parameter checks
   if (SR_W != 16) begin : g_bad_width
      $error("sreg_wlock_ctrl: SR_W must be 16");
   end
   if (SRP0_POS >= SR_W || SRP1_POS >= SR_W || BUSY_POS >= SR_W || WEL_POS >= SR_W) begin : g_bad_pos
      $error("sreg_wlock_ctrl: bit position outside status word");
   end
   if (SRP0_POS == SRP1_POS || BUSY_POS == WEL_POS ||
       SRP0_POS == BUSY_POS || SRP0_POS == WEL_POS ||
       SRP1_POS == BUSY_POS || SRP1_POS == WEL_POS) begin : g_bad_overlap
      $error("sreg_wlock_ctrl: bit positions overlap");
   end
   if (WR_CYC < 1) begin : g_bad_cyc
      $error("sreg_wlock_ctrl: WR_CYC must be at least 1");
   end

   logic [SR_W-1:0] vol_q;
   logic [SR_W-1:0] nv_q   = NV_INIT & ~RO_MASK;
   logic            perm_q = 1'b0;

   logic     busy, wel, allow, accept, nv_wr, perm_set;
   logic     wrsr_go;
   en_kind_e kind;
   logic [SR_W-1:0] wr_word;

   assign wrsr_go = wrsr_i && !busy;
   assign wr_word = wr_data_i & ~RO_MASK;

   srl_enable_latch u_en (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_nv_i  (wren_i && !busy),
      .set_vol_i (vwren_i && !busy),
      .clr_i     (wrsr_go),
      .wel_o     (wel),
      .kind_o    (kind)
   );

   srl_lock_decode u_dec (
      .srp0_i   (vol_q[SRP0_POS]),
      .srp1_i   (vol_q[SRP1_POS]),
      .perm_i   (perm_q),
      .wp_pin_i (wp_pin_i),
      .allow_o  (allow)
   );

   assign accept = wrsr_go && wel && allow;
   assign nv_wr  = accept && (kind == EN_NV);

   srl_busy_timer #(.WR_CYC(WR_CYC)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (nv_wr),
      .busy_o  (busy)
   );

   // layout variant: only the 3-bit-protect layout has a permanent lock
   if (BP4_LAYOUT) begin : g_bp4
      assign perm_set = 1'b0;
   end else begin : g_bp3
      assign perm_set = nv_wr && wr_data_i[SRP1_POS] && wr_data_i[SRP0_POS];
   end

   // volatile copy: reloaded at power-up, power-down lock dropped
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     vol_q <= perm_q ? nv_q : (nv_q & ~SRP1_MASK);
      else if (accept) vol_q <= wr_word;
   end

   // non-volatile copy: no reset, survives power cycles
   always_ff @(posedge clk_i) begin
      if (nv_wr) nv_q <= wr_word;
   end

   // sticky permanent lock: no reset
   always_ff @(posedge clk_i) begin
      if (perm_set) perm_q <= 1'b1;
   end

   always_comb begin
      sr_o           = vol_q;
      sr_o[BUSY_POS] = busy;
      sr_o[WEL_POS]  = wel;
   end

   assign nv_o        = nv_q;
   assign wel_o       = wel;
   assign busy_o      = busy;
   assign perm_lock_o = perm_q;

   AST_NO_WEL_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrsr_i && !wel) |=> ($stable(vol_q) && $stable(nv_q))); // R2
   AST_PIN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrsr_i && vol_q[SRP0_POS] && !wp_pin_i) |=> ($stable(vol_q) && $stable(nv_q))); // R3
   AST_LOCK_REFUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrsr_i && (vol_q[SRP1_POS] || perm_q)) |=> ($stable(vol_q) && $stable(nv_q))); // R4
   AST_PERM_HOLDS_SRP1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      perm_q |-> vol_q[SRP1_POS]); // R5
   AST_VOL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrsr_i && wel && (kind == EN_VOL)) |=> ($stable(nv_q) && !busy)); // R6
   AST_WEL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrsr_i |=> !wel); // R8
   AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> !wel); // R9
   AST_RO_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vol_q[BUSY_POS] == 1'b0) && (vol_q[WEL_POS] == 1'b0)); // R10
endmodule

// File: tb/test_sreg_wlock_ctrl.sv
module test_sreg_wlock_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WR_CYC     = 8;

   typedef struct packed {
      logic [1:0]  en;    // 0 none, 1 normal enable, 2 volatile enable
      logic        pin;
      logic [15:0] data;
      logic        ok;    // write expected to land
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 1'b1, 16'h00F0, 1'b0},   // R2 no enable -> refused
      '{2'd1, 1'b0, 16'h00F3, 1'b1},   // R2 mode none, pin low ok; R10 low bits dropped
      '{2'd2, 1'b1, 16'h0084, 1'b1},   // R6 volatile path
      '{2'd2, 1'b0, 16'h0000, 1'b0},   // R3 pin low -> refused
      '{2'd2, 1'b1, 16'h0004, 1'b1},   // R3 pin high -> accepted
      '{2'd2, 1'b1, 16'h0100, 1'b1},   // R4 sets power-down lock
      '{2'd1, 1'b1, 16'h0000, 1'b0},   // R4 refused
      '{2'd2, 1'b1, 16'h0000, 1'b0}    // R4 refused
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wren = 1'b0, vwren = 1'b0, wrsr = 1'b0, wp = 1'b1;
   logic [15:0] wdata = '0;
   logic [15:0] sr_a, nv_a, sr_b, nv_b;
   logic        wel_a, busy_a, perm_a, wel_b, busy_b, perm_b;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sreg_wlock_ctrl #(.BP4_LAYOUT(1'b0), .WR_CYC(WR_CYC)) i_sreg_wlock_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .vwren_i(vwren), .wrsr_i(wrsr),
      .wr_data_i(wdata), .wp_pin_i(wp), .sr_o(sr_a), .nv_o(nv_a),
      .wel_o(wel_a), .busy_o(busy_a), .perm_lock_o(perm_a));

   sreg_wlock_ctrl #(.BP4_LAYOUT(1'b1), .WR_CYC(WR_CYC)) i_sreg_wlock_ctrl_bp4 (
      .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .vwren_i(vwren), .wrsr_i(wrsr),
      .wr_data_i(wdata), .wp_pin_i(wp), .sr_o(sr_b), .nv_o(nv_b),
      .wel_o(wel_b), .busy_o(busy_b), .perm_lock_o(perm_b));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         1: wren = 1'b1;
         2: vwren = 1'b1;
         default: wrsr = 1'b1;
      endcase
      @(negedge clk);
      wren = 1'b0; vwren = 1'b0; wrsr = 1'b0;
   endtask

   task automatic do_cmd(input logic [1:0] en, input logic pin, input logic [15:0] d);
      wp = pin;
      wdata = d;
      if (en != 2'd0) pulse(int'(en));
      pulse(3);
   endtask

   task automatic wait_idle();
      while (busy_a || busy_b) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] exp_vol, exp_nv;
      int bcnt;
      exp_vol = '0;
      exp_nv  = '0;

      do_reset();
      // R1 reset state
      chk("R1 sr after reset", sr_a, 16'h0000);
      chk("R1 wel/busy after reset", {14'd0, wel_a, busy_a}, 16'h0000);
      chk("R1 perm after reset", {15'd0, perm_a}, 16'h0000);
      chk("R11 nv initial", nv_a, 16'h0000);

      for (int i = 0; i < NVEC; i++) begin
         logic nvw;
         nvw = VEC[i].ok && (VEC[i].en == 2'd1);
         do_cmd(VEC[i].en, VEC[i].pin, VEC[i].data);
         if (VEC[i].ok) exp_vol = VEC[i].data & 16'hFFFC;
         if (nvw)       exp_nv  = VEC[i].data & 16'hFFFC;
         chk($sformatf("R2/R3/R4/R10 vec%0d sr", i), sr_a, exp_vol | {15'd0, nvw});
         chk($sformatf("R2/R3/R4 vec%0d sr variant", i), sr_b, exp_vol | {15'd0, nvw});
         chk($sformatf("R6/R7 vec%0d nv", i), nv_a, exp_nv);
         chk($sformatf("R8 vec%0d wel", i), {15'd0, wel_a}, 16'h0000);
         bcnt = 0;
         while (busy_a) begin bcnt++; @(negedge clk); end
         chk($sformatf("R7 vec%0d busy cycles", i), 16'(bcnt), nvw ? 16'(WR_CYC) : 16'd0);
         wait_idle();
      end

      // R4/R11: reset drops the power-down lock, nv copy kept
      do_reset();
      chk("R4 sr after reset", sr_a, 16'h00F0);
      chk("R11 nv across reset", nv_a, 16'h00F0);

      // R9: strobes ignored while busy
      do_cmd(2'd1, 1'b1, 16'h0100);
      chk("R7 busy after nv write", {15'd0, busy_a}, 16'h0001);
      pulse(1);
      chk("R9 wren ignored while busy", {15'd0, wel_a}, 16'h0000);
      wdata = 16'h0040;
      pulse(3);
      chk("R9 wrsr ignored while busy", sr_a & 16'hFFFC, 16'h0100);
      wait_idle();

      do_reset();
      chk("R4 power-down lock cleared", sr_a, 16'h0000);
      chk("R11 nv holds lock bit", nv_a, 16'h0100);
      do_cmd(2'd2, 1'b1, 16'h0020);
      chk("R4 write after reset", sr_a, 16'h0020);
      chk("R6 nv unchanged", nv_a, 16'h0100);
      chk("R6 no busy", {15'd0, busy_a}, 16'h0000);

      // R5: mode 3 written to nv copy
      do_cmd(2'd1, 1'b1, 16'h0180);
      wait_idle();
      chk("R5 perm set 3-bit layout", {15'd0, perm_a}, 16'h0001);
      chk("R5 perm clear 4-bit layout", {15'd0, perm_b}, 16'h0000);
      do_reset();
      chk("R5 perm survives reset", {15'd0, perm_a}, 16'h0001);
      chk("R5 sr keeps lock 3-bit layout", sr_a, 16'h0180);
      chk("R5 sr unlocked 4-bit layout", sr_b, 16'h0080);
      do_cmd(2'd2, 1'b1, 16'h0004);
      chk("R5 permanent refuses", sr_a, 16'h0180);
      chk("R5 4-bit layout accepts", sr_b, 16'h0004);

      // R10: bit 1 of sr_o shows the enable latch
      pulse(1);
      chk("R10 wel bit in sr", sr_b, 16'h0006);
      chk("R10 wel bit in sr locked", sr_a, 16'h0182);
      wdata = 16'h0000;
      pulse(3);
      chk("R8 wel cleared by refused write", {15'd0, wel_a}, 16'h0000);
      wait_idle();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule